// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the bus-facing half of a small serial EEPROM. The bus clock and data lines are inputs to it. It samples both with the system clock and cleans them through a digital glitch filter. It then finds bus conditions and bit edges and runs a byte-level state machine. The storage is a register array of `MEM_BYTES` bytes, where `MEM_BYTES` is a power of two from 128 to 2048. When the array is larger than 256 bytes, the upper word-address bits travel in the device-select byte. Those bits stand in place of some of the strap-pin comparison bits. The data output is open-drain: `sda_drive_low` high means the pad pulls the line low.

A master opens every command with START and a device-select byte. Bits [7:4] of that byte are the family code. Bits [3:1] are compared with the straps or taken as high address bits. Bit 0 is the direction. A write sends one word-address byte and then data bytes. A read streams bytes from the current address for as long as the master acknowledges. A random read is a write that carries only the address, followed by a repeated START and a read select. A write that stored data starts a busy interval of `WR_BUSY_CYC` system clocks when it is closed by STOP. During that interval the device stays silent. This models the nonvolatile programming time.

The state machine has these states. ST_IDLE waits for START. ST_DEV shifts in the device-select byte. ST_WADR takes the word address. ST_WDAT stores data bytes. ST_RDAT sends data bytes. ST_SKIP stays off the bus until the next START. The transitions are as follows:
- START leads to ST_DEV from any state.
- STOP leads to ST_IDLE from any state.
- At the ninth clock of a byte:
  - ST_DEV goes to ST_WADR (write select acknowledged), to ST_RDAT (read select acknowledged), or to ST_SKIP (not acknowledged).
  - ST_WADR goes to ST_WDAT.
  - ST_WDAT stays in ST_WDAT.
  - ST_RDAT stays in ST_RDAT when the master acknowledges and goes to ST_SKIP when it does not.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A falling data edge while the clock is high is a START. A rising data edge while the clock is high is a STOP. STOP returns the block to idle. Bytes clocked without a preceding START get no acknowledge.
- R2: A device-select byte is acknowledged (data pulled low during the 9th clock) only when all of the following hold: bits [7:4] equal 4'b1010, the strap-compared bits among [3:1] equal the matching `strap_addr` bits, and the block is not busy. Otherwise the data line stays released until the next START.
- R3: With the default 512-byte array, select bits [3:2] are compared with `strap_addr[2:1]` and select bit 1 becomes word-address bit 8. In general, the lowest log2(MEM_BYTES)-8 select bits above bit 0 are address bits.
- R4: In a write, the first byte after the select byte sets the low word-address bits. Each following byte is stored at the current address, and the address then advances, wrapping modulo MEM_BYTES. Every such byte is acknowledged.
- R5: In a read, each byte goes out MSB first from the current address, and the address then advances, wrapping modulo MEM_BYTES. The line is released in the 9th clock. Another byte follows only if the master pulled the line low in that clock.
- R6: `sda_drive_low` changes only while the filtered bus clock is low.
- R7: While `wr_protect` is high, no array byte changes. Write bytes are still acknowledged.
- R8: A pulse on either line shorter than FILT_CYC system clocks is ignored and creates no START or STOP.
- R9: A STOP that ends a write which stored at least one byte raises `write_busy` for WR_BUSY_CYC clocks. While busy, the device-select byte gets no acknowledge.
- R10: After reset the data line is released, `write_busy` is low and every array byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_addr | input | 3 | Strap pins compared against device-select bits [3:1] |
| wr_protect | input | 1 | High blocks all array writes |
| sda_drive_low | output | 1 | High pulls the data line low (open-drain) |
| write_busy | output | 1 | High during the modelled programming interval |

## Verification
The assertions check four things on every cycle: the output drive changes only while the filtered clock is low, the block stays silent in the skip state and during a busy select, busy starts only from a STOP, and a START always restarts select reception. The bench's scenarios cover the rest. They show stored and read-back data, the page bit, address wrap-around, write protection, strap mismatch, the refusal without START, and glitch rejection. A bus-level reference memory in the bench predicts every driven bit and every acknowledge.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_WADR,
        ST_WDAT,
        ST_RDAT,
        ST_SKIP
    } ee_state_t;

    localparam logic [3:0] FAMILY_CODE = 4'b1010;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic flt
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic [1:0]    sync;
    logic [CW-1:0] cnt;

    // a new level is accepted only after FILT_CYC consecutive samples disagree
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync <= 2'b11;
            cnt  <= '0;
            flt  <= 1'b1;
        end else begin
            sync <= {sync[0], raw};
            if (sync[1] == flt) begin
                cnt <= '0;
            end else if (cnt == CW'(FILT_CYC - 1)) begin
                flt <= sync[1];
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
    import i2c_ee_pkg::*;
#(
    parameter int MEM_BYTES   = 512,
    parameter int FILT_CYC    = 4,
    parameter int WR_BUSY_CYC = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_addr,
    input  logic       wr_protect,
    output logic       sda_drive_low,
    output logic       write_busy
);
    localparam int AW    = $clog2(MEM_BYTES);
    localparam int PG    = (AW > 8) ? AW - 8 : 0;
    localparam int LOW_W = (AW > 8) ? 8 : AW;
    localparam int BW    = $clog2(WR_BUSY_CYC + 1);
    localparam logic [2:0] STRAP_MASK = 3'b111 << PG;

    // ---- input conditioning: one filter per bus line ----
    logic [1:0] raw_lines, flt_lines;
    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        i2c_line_filter #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk(clk), .rst_n(rst_n), .raw(raw_lines[g]), .flt(flt_lines[g])
        );
    end

    logic scl_f, sda_f, scl_q, sda_q;
    assign scl_f = flt_lines[1];
    assign sda_f = flt_lines[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    logic scl_rise, scl_fall, start_det, stop_det;
    assign scl_rise  = scl_f & ~scl_q;
    assign scl_fall  = ~scl_f & scl_q;
    assign start_det = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;

    // ---- state and datapath registers ----
    ee_state_t     state, state_nx;
    logic [3:0]    bitcnt;
    logic [7:0]    shreg, tx;
    logic [AW-1:0] addr, sel_addr, rd_addr;
    logic [7:0]    rd_data;
    logic          ack_ok, ack_now, dev_ok, straps_ok, wrote, mem_we, active;
    logic [BW-1:0] busy_cnt;

    assign straps_ok  = ((shreg[3:1] ^ strap_addr) & STRAP_MASK) == 3'b000;
    assign write_busy = busy_cnt != '0;
    assign dev_ok     = (shreg[7:4] == FAMILY_CODE) && straps_ok && !write_busy;
    assign active     = (state == ST_DEV) || (state == ST_WADR) ||
                        (state == ST_WDAT) || (state == ST_RDAT);

    if (PG > 0) begin : g_page
        assign sel_addr = {shreg[PG:1], addr[LOW_W-1:0]};
    end else begin : g_nopage
        assign sel_addr = addr;
    end

    assign rd_addr = (state == ST_DEV) ? sel_addr : addr + 1'b1;

    always_comb begin
        unique case (state)
            ST_DEV:           ack_now = dev_ok;
            ST_WADR, ST_WDAT: ack_now = 1'b1;
            default:          ack_now = 1'b0;
        endcase
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = ST_DEV;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (scl_rise && bitcnt == 4'd8) begin
            unique case (state)
                ST_DEV:  state_nx = !ack_ok ? ST_SKIP : (shreg[0] ? ST_RDAT : ST_WADR);
                ST_WADR: state_nx = ST_WDAT;
                ST_WDAT: state_nx = ST_WDAT;
                ST_RDAT: state_nx = sda_f ? ST_SKIP : ST_RDAT;
                default: state_nx = state;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assign mem_we = (state == ST_WDAT) && scl_rise && (bitcnt == 4'd8) &&
                    !wr_protect && !start_det && !stop_det;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt <= '0;
            shreg  <= '0;
            tx     <= '0;
            addr   <= '0;
            ack_ok <= 1'b0;
            wrote  <= 1'b0;
        end else if (start_det) begin
            bitcnt <= '0;
        end else if (stop_det) begin
            bitcnt <= '0;
            wrote  <= 1'b0;
        end else begin
            if (scl_fall && bitcnt == 4'd8) ack_ok <= ack_now;
            if (scl_rise && active) begin
                if (bitcnt != 4'd8) begin
                    shreg  <= {shreg[6:0], sda_f};
                    bitcnt <= bitcnt + 1'b1;
                end else begin
                    bitcnt <= '0;
                    unique case (state)
                        ST_DEV: if (ack_ok) begin
                            addr <= sel_addr;
                            tx   <= rd_data;
                        end
                        ST_WADR: addr[LOW_W-1:0] <= shreg[LOW_W-1:0];
                        ST_WDAT: begin
                            addr  <= addr + 1'b1;
                            wrote <= wrote | !wr_protect;
                        end
                        ST_RDAT: begin
                            addr <= addr + 1'b1;
                            tx   <= rd_data;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // output process: the pad drive moves only on a clock fall
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_drive_low <= 1'b0;
        end else if (start_det || stop_det) begin
            sda_drive_low <= 1'b0;
        end else if (scl_fall) begin
            unique case (state)
                ST_RDAT:                  sda_drive_low <= (bitcnt != 4'd8) && !tx[3'd7 - bitcnt[2:0]];
                ST_DEV, ST_WADR, ST_WDAT: sda_drive_low <= (bitcnt == 4'd8) && ack_now;
                default:                  sda_drive_low <= 1'b0;
            endcase
        end
    end

    // modelled programming interval
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  busy_cnt <= '0;
        else if (stop_det && wrote)  busy_cnt <= BW'(WR_BUSY_CYC);
        else if (busy_cnt != '0)     busy_cnt <= busy_cnt - 1'b1;
    end

    eeprom_array #(.DEPTH(MEM_BYTES), .AW(AW)) u_array (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(addr), .wdata(shreg),
        .raddr(rd_addr), .rdata(rd_data)
    );
endmodule

// File: rtl/i2c_eeprom_slave_chk.sv
module i2c_eeprom_slave_chk
    import i2c_ee_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_f,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_drive_low,
    input logic       write_busy,
    input ee_state_t  state,
    input logic [3:0] bitcnt
);
    assert_drive_on_low_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_low) |-> !scl_f);

    assert_skip_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> !sda_drive_low);

    assert_busy_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (write_busy && state == ST_DEV) |-> !sda_drive_low);

    assert_busy_from_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(write_busy) |-> $past(stop_det));

    assert_start_restarts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_DEV && bitcnt == 4'd0));

    assert_bit_count_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= 4'd8);
endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .start_det(start_det),
    .stop_det(stop_det), .sda_drive_low(sda_drive_low), .write_busy(write_busy),
    .state(state), .bitcnt(bitcnt)
);

// File: tb/i2c_eeprom_slave_tb.sv
module i2c_eeprom_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 24;
    localparam int MEMB       = 512;
    localparam int BUSY       = 1000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
    logic [2:0] straps = 3'b101;
    logic drive_low, busy, sda_bus;
    int total = 0, bad = 0;
    bit done = 1'b0;
    bit care = 1'b0, exp_low = 1'b0;
    string cur_req = "R10";
    logic [7:0] ref_mem [MEMB];

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_bus = sda_m & ~drive_low;

    i2c_eeprom_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .strap_addr(straps), .wr_protect(wp),
        .sda_drive_low(drive_low), .write_busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison of the pad drive against the bench model
    always @(posedge clk) begin
        #1;
        if (care && !done) check(drive_low == exp_low, cur_req, drive_low, exp_low);
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(H/2);
        scl_m = 1'b1; wait_clk(H/2);
        sda_m = 1'b0; wait_clk(H/2);
        scl_m = 1'b0; wait_clk(H/2);
    endtask

    task automatic bus_stop();
        scl_m = 1'b0; wait_clk(H/2);
        sda_m = 1'b0; wait_clk(H/2);
        scl_m = 1'b1; wait_clk(H/2);
        sda_m = 1'b1; wait_clk(H);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        scl_m = 1'b0;
        for (int i = 0; i < 8; i++) begin
            wait_clk(H/2); sda_m = b[7-i];
            wait_clk(H/2); scl_m = 1'b1;
            wait_clk(H);   scl_m = 1'b0;
        end
        wait_clk(H/2); sda_m = 1'b1;
        wait_clk(H/2); scl_m = 1'b1;
        cur_req = req; exp_low = exp_ack;
        wait_clk(8); care = 1'b1;
        wait_clk(H-10); care = 1'b0;
        check(sda_bus == !exp_ack, req, sda_bus, !exp_ack);
        wait_clk(2); scl_m = 1'b0;
    endtask

    task automatic recv_byte(input logic [7:0] expb, input bit m_ack, input string req);
        logic [7:0] got;
        got = '0;
        scl_m = 1'b0;
        cur_req = req;
        for (int i = 0; i < 8; i++) begin
            wait_clk(H/2); sda_m = 1'b1;
            wait_clk(H/2); scl_m = 1'b1;
            exp_low = !expb[7-i];
            wait_clk(8); care = 1'b1;
            wait_clk(H-10); care = 1'b0;
            got[7-i] = sda_bus;
            wait_clk(2); scl_m = 1'b0;
        end
        check(got == expb, req, got, expb);
        wait_clk(H/2); sda_m = !m_ack;
        wait_clk(H/2); scl_m = 1'b1;
        exp_low = 1'b0;
        wait_clk(8); care = 1'b1;
        wait_clk(H-10); care = 1'b0;
        wait_clk(2); scl_m = 1'b0;
    endtask

    function automatic logic [7:0] dsel(input bit page, input bit rd);
        return {4'b1010, 2'b10, page, rd};
    endfunction

    task automatic wr_txn(input bit page, input logic [7:0] lo, input logic [7:0] d [$], input string req);
        int a;
        a = {page, lo};
        bus_start();
        send_byte(dsel(page, 1'b0), 1'b1, "R2");
        send_byte(lo, 1'b1, req);
        foreach (d[k]) begin
            send_byte(d[k], 1'b1, req);
            if (!wp) ref_mem[a] = d[k];
            a = (a + 1) % MEMB;
        end
        bus_stop();
    endtask

    task automatic rd_txn(input bit page, input logic [7:0] lo, input int n, input string req);
        int a;
        a = {page, lo};
        bus_start();
        send_byte(dsel(page, 1'b0), 1'b1, "R2");
        send_byte(lo, 1'b1, "R4");
        bus_start();
        send_byte(dsel(page, 1'b1), 1'b1, "R1");
        for (int k = 0; k < n; k++) begin
            recv_byte(ref_mem[a], k != n-1, req);
            a = (a + 1) % MEMB;
        end
        bus_stop();
    endtask

    initial begin
        repeat (BUSY * 150) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] q [$];
        for (int i = 0; i < MEMB; i++) ref_mem[i] = 8'h00;
        wait_clk(5);
        // R10: reset state
        check(drive_low == 1'b0, "R10", drive_low, 0);
        check(busy == 1'b0, "R10", busy, 0);
        rst_n = 1'b1;
        wait_clk(10);
        check(drive_low == 1'b0 && busy == 1'b0, "R10", {drive_low, busy}, 0);
        rd_txn(1'b0, 8'h40, 1, "R10");

        // R4: write three bytes in page 0
        q = '{8'h11, 8'h22, 8'h33};
        wr_txn(1'b0, 8'h10, q, "R4");
        check(busy == 1'b1, "R9", busy, 1);
        // R9: no acknowledge while busy
        bus_start();
        send_byte(dsel(1'b0, 1'b0), 1'b0, "R9");
        bus_stop();
        wait_clk(BUSY);
        check(busy == 1'b0, "R9", busy, 0);

        // R5: sequential read
        rd_txn(1'b0, 8'h10, 3, "R5");

        // R3: page bit selects word-address bit 8
        q = '{8'hAA, 8'hBB};
        wr_txn(1'b1, 8'h05, q, "R3");
        wait_clk(BUSY + 10);
        rd_txn(1'b1, 8'h05, 2, "R3");
        rd_txn(1'b0, 8'h05, 1, "R3");

        // R4 and R5: wrap at the end of the array
        q = '{8'h01, 8'h02, 8'h03};
        wr_txn(1'b1, 8'hFE, q, "R4");
        wait_clk(BUSY + 10);
        check(ref_mem[0] == 8'h03, "R4", ref_mem[0], 8'h03);
        rd_txn(1'b1, 8'hFE, 3, "R5");

        // R7: protected write is acknowledged but stores nothing
        wp = 1'b1;
        q = '{8'h55};
        wr_txn(1'b0, 8'h10, q, "R7");
        wp = 1'b0;
        wait_clk(4);
        check(busy == 1'b0, "R7", busy, 0);
        rd_txn(1'b0, 8'h10, 1, "R7");

        // R2: strap mismatch and wrong family code, line stays released
        bus_start();
        send_byte(8'b1010_0100, 1'b0, "R2");
        send_byte(8'h00, 1'b0, "R2");
        bus_stop();
        bus_start();
        send_byte(8'hB8, 1'b0, "R2");
        bus_stop();

        // R1: no acknowledge without START
        send_byte(dsel(1'b0, 1'b0), 1'b0, "R1");
        bus_stop();

        // R8: short low pulse on data while clock high is no START
        wait_clk(H);
        sda_m = 1'b0; wait_clk(2); sda_m = 1'b1;
        wait_clk(H);
        send_byte(dsel(1'b0, 1'b0), 1'b0, "R8");
        bus_stop();
        // R8: the block still answers a proper command afterwards
        rd_txn(1'b0, 8'h11, 1, "R8");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule